// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the host side of a two-wire PHY management link. The host gives it one command at a time. A command is a read or a write, a 5-bit PHY address, a 5-bit register address and, for a write, 16 bits of data. The block then serialises a complete management frame on the clock pin and the data-out pin. It drives the data-out enable so that an external tri-state buffer can share the data line. It samples the data-in pin during the read phase.

When the frame is finished, the block raises a one-cycle done pulse. After a read, the 16 received bits are on the result port at that time. The host sets the length of one clock phase, in system clock cycles, through a port. With a 250 MHz system clock, a value of 250 gives the usual 1 µs per phase.

The pin state is also mirrored onto a 4-bit image that a register interface can expose:

| Bit | Meaning |
|-----|---------|
| 0 | Clock |
| 1 | Drive enable |
| 2 | Output bit |
| 3 | Input bit |

Top module: `mdio_frame_master`

## Requirements
- R1: Every frame begins with 32 driven ones, then the start pattern 01, then the opcode (10 = read, 01 = write), then the PHY address and then the register address. Every field goes out MSB first.
- R2: Each driven bit spans three phases: clock low, clock high, clock low. The enable is high in all three phases, and the output bit does not change while the clock is high.
- R3: After the register address of a read, the line is released for one low/high/low cycle. Then 16 bits are clocked in, each as a high phase followed by a low phase. Each bit is sampled at the end of its high phase. The first bit received is the MSB of `rdData`, and `rdData` is valid when `done` pulses.
- R4: A write drives the turnaround pattern 10 after the register address, then the 16 data bits MSB first. It then holds one final phase with the enable low and the clock low.
- R5: A phase lasts `phaseLen` system cycles, and a value of 0 acts as 1. From the accepting edge to the end of the frame, a read takes 173 phases and a write takes 193 phases. This gives `busy` high for 173·L+1 cycles on a read and 193·L+1 cycles on a write.
- R6: `busy` rises in the cycle after `cmdValid` is accepted and stays high through the cycle of `done`. `done` is high for exactly one cycle, and only while `busy` is high.
- R7: `cmdValid` is accepted only while `busy` is low. A command presented during a frame alters neither that frame nor its result, and it starts no further frame.
- R8: Out of reset and whenever `busy` is low, the clock and the enable are low. The enable is also low during the release cycle and during every read data bit.
- R9: `pinImage` shows the current pins as bit0 = `mdc`, bit1 = `mdoEn`, bit2 = `mdo`, bit3 = `mdi`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseLen | input | DIV_W | System cycles per clock phase (0 acts as 1) |
| cmdValid | input | 1 | Command strobe, taken when not busy |
| cmdRead | input | 1 | 1 = read, 0 = write |
| cmdPhyAddr | input | ADDR_W | Target PHY address |
| cmdRegAddr | input | ADDR_W | Target register address |
| cmdWrData | input | DATA_W | Data for a write |
| rdData | output | DATA_W | Data from the last read, valid with done |
| done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock pin |
| mdo | output | 1 | Management data out |
| mdoEn | output | 1 | Drive enable for mdo |
| mdi | input | 1 | Management data in |
| pinImage | output | 4 | Pin mirror: clock, enable, out, in |

## Verification
The bench builds the block with its default widths: 5-bit addresses, 16-bit data and a 16-bit phase divider. It drives `phaseLen` at run time with 1, 3 and 0. The phase length of 1 gives the tightest back-to-back phase switching. The length of 3 puts several system cycles inside each phase, so a command can arrive mid-phase and must be ignored. The length of 0 exercises the clamp to one cycle. Short phases keep full 64-bit frames within a few hundred cycles, so the cycle-exact frame lengths can be checked for both read and write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef struct packed {
    logic load;      // capture a new command into the datapath
    logic shiftTx;   // advance the transmit shifter by one bit
    logic sampleRx;  // take the input pin into the receive shifter
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DRIVE, S_REL, S_READ, S_TAIL, S_FIN
  } mdioState_t;
endpackage

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int DIV_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [DIV_W-1:0]  phaseLen,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] cmdPhyAddr,
  input  logic [ADDR_W-1:0] cmdRegAddr,
  input  logic [DATA_W-1:0] cmdWrData,
  input  logic              mdi,
  output logic              tick,
  output logic              mdo,
  output logic [DATA_W-1:0] rdData
);
  localparam int FRAME_W = PRE_BITS + 4 + 2*ADDR_W + 2 + DATA_W;

  logic [DIV_W-1:0]   phaseCnt;
  logic [DIV_W-1:0]   lenM1;
  logic [FRAME_W-1:0] txShift;
  logic [DATA_W-1:0]  rxShift;

  assign lenM1 = (phaseLen == '0) ? '0 : phaseLen - 1'b1;
  assign tick  = (phaseCnt == '0);

  // phase timer: reloads on a new command and at the end of every phase
  always_ff @(posedge clk) begin
    if (!rstN)                      phaseCnt <= '0;
    else if (strb.load || tick)     phaseCnt <= lenM1;
    else                            phaseCnt <= phaseCnt - 1'b1;
  end

  // transmit image: preamble, start, opcode, addresses, turnaround, data
  always_ff @(posedge clk) begin
    if (!rstN)
      txShift <= '0;
    else if (strb.load)
      txShift <= {{PRE_BITS{1'b1}}, 2'b01, (cmdRead ? 2'b10 : 2'b01),
                  cmdPhyAddr, cmdRegAddr, 2'b10, cmdWrData};
    else if (strb.shiftTx)
      txShift <= {txShift[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.load) rxShift <= '0;
    else if (strb.sampleRx) rxShift <= {rxShift[DATA_W-2:0], mdi};
  end

  assign mdo    = txShift[FRAME_W-1];
  assign rdData = rxShift;
endmodule

// File: rtl/mdio_control.sv
module mdio_control
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdRead,
  input  logic       tick,
  output ctlStrobe_t strb,
  output logic       mdc,
  output logic       mdoEn,
  output logic       busy,
  output logic       done
);
  localparam int FRAME_W = PRE_BITS + 4 + 2*ADDR_W + 2 + DATA_W;
  localparam int RD_BITS = FRAME_W - 2 - DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W);

  mdioState_t       state, stateN;
  logic [1:0]       phase, phaseN;
  logic [CNT_W-1:0] bitCnt, cntN;
  logic             isReadQ;
  logic             mdcN, enN;

  always_comb begin
    stateN = state;
    phaseN = phase;
    cntN   = bitCnt;
    strb   = '0;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        strb.load = 1'b1;
        stateN    = S_DRIVE;
        phaseN    = '0;
        cntN      = cmdRead ? CNT_W'(RD_BITS - 1) : CNT_W'(FRAME_W - 1);
      end
      S_DRIVE: if (tick) begin
        if (phase == 2'd2) begin
          phaseN = '0;
          if (bitCnt == '0) stateN = isReadQ ? S_REL : S_TAIL;
          else begin
            cntN         = bitCnt - 1'b1;
            strb.shiftTx = 1'b1;
          end
        end else phaseN = phase + 2'd1;
      end
      S_REL: if (tick) begin
        if (phase == 2'd2) begin
          stateN = S_READ;
          phaseN = '0;
          cntN   = CNT_W'(DATA_W - 1);
        end else phaseN = phase + 2'd1;
      end
      S_READ: if (tick) begin
        if (phase == 2'd0) begin
          strb.sampleRx = 1'b1;
          phaseN        = 2'd1;
        end else begin
          phaseN = '0;
          if (bitCnt == '0) stateN = S_FIN;
          else              cntN   = bitCnt - 1'b1;
        end
      end
      S_TAIL: if (tick) stateN = S_FIN;
      S_FIN:  stateN = S_IDLE;
      default: stateN = S_IDLE;
    endcase
  end

  // pins are registered from the next state so they never glitch
  assign mdcN = ((stateN == S_DRIVE || stateN == S_REL) && phaseN == 2'd1) ||
                (stateN == S_READ && phaseN == 2'd0);
  assign enN  = (stateN == S_DRIVE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= '0;
      bitCnt  <= '0;
      isReadQ <= 1'b0;
      mdc     <= 1'b0;
      mdoEn   <= 1'b0;
    end else begin
      state  <= stateN;
      phase  <= phaseN;
      bitCnt <= cntN;
      if (strb.load) isReadQ <= cmdRead;
      mdc    <= mdcN;
      mdoEn  <= enN;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int DIV_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  phaseLen,
  input  logic              cmdValid,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] cmdPhyAddr,
  input  logic [ADDR_W-1:0] cmdRegAddr,
  input  logic [DATA_W-1:0] cmdWrData,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              busy,
  output logic              mdc,
  output logic              mdo,
  output logic              mdoEn,
  input  logic              mdi,
  output logic [3:0]        pinImage
);
  ctlStrobe_t strb;
  logic       tick;

  mdio_control #(.PRE_BITS(PRE_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .tick(tick), .strb(strb), .mdc(mdc), .mdoEn(mdoEn), .busy(busy), .done(done)
  );

  mdio_datapath #(.PRE_BITS(PRE_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .phaseLen(phaseLen),
    .cmdRead(cmdRead), .cmdPhyAddr(cmdPhyAddr), .cmdRegAddr(cmdRegAddr),
    .cmdWrData(cmdWrData), .mdi(mdi), .tick(tick), .mdo(mdo), .rdData(rdData)
  );

  assign pinImage = {mdi, mdo, mdoEn, mdc};
endmodule

// File: rtl/mdio_frame_checker.sv
module mdio_frame_checker (
  input logic clk,
  input logic rstN,
  input logic mdc,
  input logic mdo,
  input logic mdoEn,
  input logic busy,
  input logic done
);
  // R8: released and clock low whenever no frame runs
  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdoEn && !mdc));
  // R6: done lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6: done only inside a frame
  p_done_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  // R2: output bit holds while the clock stays high
  p_mdo_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdo));
  // R2: the drive is released only while the clock is low
  p_release_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mdoEn) |-> !mdc);
endmodule

bind mdio_frame_master mdio_frame_checker u_chk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdo(mdo), .mdoEn(mdoEn),
  .busy(busy), .done(done)
);

// File: tb/tb_mdio_frame_master.sv
module tb_mdio_frame_master;
  typedef struct {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] data;
  } item_t;

  logic clk = 0, rstN = 0;
  logic [15:0] phaseLen = 16'd1;
  logic cmdValid = 0, cmdRead = 0;
  logic [4:0] cmdPhyAddr = 0, cmdRegAddr = 0;
  logic [15:0] cmdWrData = 0;
  logic [15:0] rdData;
  logic done, busy, mdc, mdo, mdoEn;
  logic mdi = 0;
  logic [3:0] pinImage;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  item_t frameQ[$];
  item_t resultQ[$];

  always #2 clk = ~clk;

  mdio_frame_master dut (
    .clk(clk), .rstN(rstN), .phaseLen(phaseLen), .cmdValid(cmdValid),
    .cmdRead(cmdRead), .cmdPhyAddr(cmdPhyAddr), .cmdRegAddr(cmdRegAddr),
    .cmdWrData(cmdWrData), .rdData(rdData), .done(done), .busy(busy),
    .mdc(mdc), .mdo(mdo), .mdoEn(mdoEn), .mdi(mdi), .pinImage(pinImage)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // responder: decodes frames from clock rising edges and answers reads
  logic [63:0] cap = '0;
  int nb = 0, rdLeft = 0;
  bit relPending = 0, prevMdc = 0;
  logic [15:0] resp = '0;
  always @(negedge clk) begin
    if (rstN && mdc && !prevMdc) begin
      check(pinImage == {mdi, mdo, mdoEn, mdc}, "R9 pin image", pinImage, {mdi, mdo, mdoEn, mdc});
      if (mdoEn) begin
        cap = {cap[62:0], mdo};
        nb++;
        if (nb == 46 && cap[11:10] == 2'b10) begin
          item_t e;
          e = frameQ.pop_front();
          check(cap[45:0] == {32'hFFFF_FFFF, 2'b01, 2'b10, e.phy, e.rg}, "R1 read header",
                cap[45:0], {32'hFFFF_FFFF, 2'b01, 2'b10, e.phy, e.rg});
          resp = e.data;
          relPending = 1;
          nb = 0;
        end else if (nb == 64) begin
          item_t e;
          e = frameQ.pop_front();
          check(cap == {32'hFFFF_FFFF, 2'b01, 2'b01, e.phy, e.rg, 2'b10, e.data}, "R4 write frame",
                cap, {32'hFFFF_FFFF, 2'b01, 2'b01, e.phy, e.rg, 2'b10, e.data});
          nb = 0;
        end
      end else if (relPending) begin
        relPending = 0;
        rdLeft = 16;
      end else if (rdLeft > 0) begin
        check(!mdoEn, "R8 read data released", mdoEn, 0);
        mdi = resp[rdLeft-1];
        rdLeft--;
      end
    end
    prevMdc = mdc;
  end

  // monitor: compares results as done pulses
  always @(negedge clk) begin
    if (rstN && done) begin
      item_t e;
      e = resultQ.pop_front();
      if (e.rd) check(rdData == e.data, "R3 read data", rdData, e.data);
      check(!mdoEn && !mdc, "R4 idle phase released low", {mdoEn, mdc}, 0);
    end
  end

  task automatic doOp(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                      input logic [15:0] data, input bit intrude);
    int n, lenEff, expCyc;
    item_t e;
    e.rd = rd; e.phy = phy; e.rg = rg; e.data = data;
    frameQ.push_back(e);
    resultQ.push_back(e);
    lenEff = (phaseLen == 0) ? 1 : int'(phaseLen);
    expCyc = (rd ? 173 : 193) * lenEff + 1;
    @(negedge clk);
    cmdValid = 1; cmdRead = rd; cmdPhyAddr = phy; cmdRegAddr = rg; cmdWrData = data;
    @(negedge clk);
    cmdValid = 0;
    check(busy == 1, "R6 busy after accept", busy, 1);
    n = 1;
    forever begin
      if (intrude && n == 20) begin
        // R7: a command mid-frame must be ignored
        cmdValid = 1; cmdRead = ~rd; cmdPhyAddr = ~phy; cmdRegAddr = ~rg; cmdWrData = ~data;
      end else cmdValid = 0;
      if (done) break;
      @(negedge clk);
      if (busy) n++;
    end
    cmdValid = 0;
    check(n == expCyc, "R5 frame length", n, expCyc);
    @(negedge clk);
    check(busy == 0, "R6 busy clears after done", busy, 0);
    if (intrude) begin
      repeat (10 * lenEff) @(negedge clk);
      check(busy == 0 && frameQ.size() == 0, "R7 no extra frame", busy, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R6 reset busy/done", {busy, done}, 0);
    check(mdc == 0 && mdoEn == 0, "R8 reset pins", {mdc, mdoEn}, 0);
    check(pinImage == 4'b0000, "R9 reset image", pinImage, 0);
    rstN = 1;
    @(negedge clk);
    phaseLen = 16'd1;
    doOp(0, 5'd1, 5'd0, 16'hA5C3, 0);
    doOp(1, 5'd31, 5'd1, 16'h8001, 0);
    phaseLen = 16'd3;
    doOp(1, 5'd0, 5'd31, 16'hFFFF, 0);
    doOp(0, 5'd10, 5'd21, 16'h0000, 1);
    doOp(1, 5'd5, 5'd4, 16'h3C5A, 1);
    phaseLen = 16'd0;
    doOp(1, 5'd17, 5'd9, 16'h1234, 0);
    doOp(0, 5'd22, 5'd14, 16'hFEDC, 0);
    repeat (5) @(negedge clk);
    check(frameQ.size() == 0 && resultQ.size() == 0, "R1 all frames seen", frameQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule